// File: doc/BRIEF.md
# Capture-Compare Timer Event Unit

A single timer channel built around a free-running counter that advances on every system clock. The counter is compared against a programmable reference value, and a synchronized external input can snapshot the counter on a chosen edge. Each of the two events (reference match and input capture) sets a sticky flag. Software clears a flag by writing a one to its bit.

A small word-wide register port selects one of four registers by a 2-bit address. Address 0 holds the mode bits, address 1 the reference value, address 2 the captured value (read only) and address 3 the event flags. Reads are combinational from the address. Writes take effect at the rising clock edge while the write strobe is high. Each set flag drives one output, either the interrupt line or the DMA request line. One mode bit chooses which of the two outputs the events use.

Top module: `cc_timer_event`

## Requirements
- R1: After reset the reference register reads 0xFFFF_FFFF, the capture register reads 0, the mode register reads 0, the event register reads 0, and both `irq` and `dma_req` are low. The counter starts at 0 and adds one on every clock edge after reset.
- R2: The reference flag (event bit 1) is set at the clock edge where the counter value exactly equals the reference register. It is never set at any other counter value.
- R3: `cap_in` passes through two synchronizing flops before edge detection. On a selected edge, the capture register loads the counter and the capture flag (event bit 0) sets. The stored value is the counter value seen at the input change plus 2.
- R4: Mode bits [1:0] select the capture edge: 00 no capture, 01 rising edge only, 10 falling edge only, 11 either edge. An edge that is not selected leaves the flag clear.
- R5: The event register is at address 3, with the reference flag in bit 1 and the capture flag in bit 0. Bits 31:2 always read as zero.
- R6: Writing a one to an event bit clears that flag. Writing a zero leaves the flag unchanged, whatever is written to bits 31:2.
- R7: If an event occurs in the same cycle as a write-one-to-clear of its flag, the flag stays set.
- R8: Mode bit 2 enables the reference event and mode bit 3 selects DMA routing. With the reference flag set: bit 2 = 0 asserts nothing, bit 2 = 1 with bit 3 = 0 asserts `irq`, and bit 2 = 1 with bit 3 = 1 asserts `dma_req`.
- R9: When the capture flag is set and mode bits [1:0] are not 00, mode bit 3 = 0 asserts `irq` and bit 3 = 1 asserts `dma_req`.
- R10: `irq` and `dma_req` are level outputs that are never high together. They fall in the cycle that follows the clock edge that clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also clocks the counter |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register select: 0 mode, 1 reference, 2 capture, 3 events |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | DMA request level |

## Verification
The assertions assume that `addr` and `wr_data` are stable around the clock edge when `wr_en` is high. They also assume that `cap_in` stays at a level for at least three clocks, so the synchronizer sees each change as one edge. The stimulus changes `cap_in` and the port signals only on the falling clock edge. Before sampling, it holds each input level for four or more clocks. The set-versus-clear case is reached by timing the clear write so that it lands on the edge where the counter matches the reference.

// File: rtl/cc_timer_event.sv
module cc_timer_event #(
  parameter int CNT_W = 32,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             cap_in,
  output logic             irq,
  output logic             dma_req
);
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_REF  = AW'(1);
  localparam logic [AW-1:0] A_CAP  = AW'(2);
  localparam logic [AW-1:0] A_EV   = AW'(3);
  localparam int MODE_W = 4;

  logic [CNT_W-1:0] cnt, ref_q, cap_q;
  logic [MODE_W-1:0] mode_q;
  logic [1:0] sync_q;
  logic cap_prev, ev_ref, ev_cap;

  wire [1:0] edge_sel = mode_q[1:0];
  wire       ref_ie   = mode_q[2];
  wire       dma_en   = mode_q[3];
  wire       cap_on   = |edge_sel;

  wire rise    = sync_q[1] & ~cap_prev;
  wire fall    = ~sync_q[1] & cap_prev;
  wire cap_hit = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  wire ref_hit = (cnt == ref_q);
  wire ev_wr   = wr_en && (addr == A_EV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sync_q   <= '0;
      cap_prev <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
      sync_q   <= {sync_q[0], cap_in};
      cap_prev <= sync_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '1;
    end else if (wr_en) begin
      if (addr == A_MODE) mode_q <= wr_data[MODE_W-1:0];
      if (addr == A_REF)  ref_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_hit) cap_q <= cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_ref <= 1'b0;
      ev_cap <= 1'b0;
    end else begin
      ev_ref <= ref_hit | (ev_ref & ~(ev_wr & wr_data[1]));
      ev_cap <= cap_hit | (ev_cap & ~(ev_wr & wr_data[0]));
    end
  end

  always_comb begin
    unique case (addr)
      A_MODE:  rd_data = {{(CNT_W-MODE_W){1'b0}}, mode_q};
      A_REF:   rd_data = ref_q;
      A_CAP:   rd_data = cap_q;
      default: rd_data = {{(CNT_W-2){1'b0}}, ev_ref, ev_cap};
    endcase
  end

  wire pend = (ev_ref & ref_ie) | (ev_cap & cap_on);
  assign irq     = pend & ~dma_en;
  assign dma_req = pend & dma_en;

  // R2
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == ref_q) |=> ev_ref);
  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EV && wr_data[1] && cnt != ref_q) |=> !ev_ref);
  // R6
  w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cap && !(wr_en && addr == A_EV && wr_data[0])) |=> ev_cap);
  // R4
  cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00 && !ev_cap) |=> !ev_cap);
  // R10
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));
  // R3
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_cap) |-> cap_q == $past(cnt));
endmodule

// File: tb/cc_timer_event_bench.sv
module cc_timer_event_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic cap_in = 1'b0;
  logic irq, dma_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] cnt_model;

  always #2.5 clk = ~clk;

  cc_timer_event u_cc_timer_event (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cap_in(cap_in),
    .irq(irq), .dma_req(dma_req));

  always_ff @(posedge clk) cnt_model <= rst_n ? cnt_model + 1 : 32'd0;

  // [7:4] mode, [3] rising transition, [2] capture expected, [1] irq, [0] dma
  localparam logic [7:0] VEC [8] = '{
    8'b0000_1000, 8'b0001_1110, 8'b0001_0000, 8'b0010_0110,
    8'b0010_1000, 8'b0011_1110, 8'b1011_0101, 8'b1001_1101};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rd_data;
  endtask

  initial begin
    logic [31:0] v, snap, tgt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd1, v); chk("R1 ref reset", v, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R1 cap reset", v, 32'h0);
    rd(2'd0, v); chk("R1 mode reset", v, 32'h0);
    rd(2'd3, v); chk("R1 event reset", v, 32'h0);
    chk("R1 outputs reset", {30'd0, irq, dma_req}, 32'h0);

    // R3 R4 R9 capture vectors
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {28'd0, VEC[i][7:4]});
      @(negedge clk); cap_in = ~VEC[i][3];
      repeat (5) @(negedge clk);
      wr(2'd3, 32'h3);
      rd(2'd3, v); chk($sformatf("R6 pre-clear vec%0d", i), v, 32'h0);
      @(negedge clk); snap = cnt_model; cap_in = VEC[i][3];
      repeat (4) @(negedge clk);
      rd(2'd3, v); chk($sformatf("R4 cap flag vec%0d", i), v, {31'd0, VEC[i][2]});
      if (VEC[i][2]) begin
        rd(2'd2, v); chk($sformatf("R3 cap value vec%0d", i), v, snap + 32'd2);
      end
      chk($sformatf("R9 routing vec%0d", i), {30'd0, irq, dma_req}, {30'd0, VEC[i][1:0]});
    end

    // R2 R8 reference match
    wr(2'd0, 32'h4);
    wr(2'd3, 32'h3);
    tgt = cnt_model + 32'd10;
    wr(2'd1, tgt);
    rd(2'd3, v); chk("R2 no early match", v, 32'h0);
    repeat (12) @(negedge clk);
    rd(2'd3, v); chk("R2 match flag", v, 32'h2);
    chk("R8 irq route", {30'd0, irq, dma_req}, 32'h2);
    wr(2'd0, 32'h0);
    chk("R8 disabled", {30'd0, irq, dma_req}, 32'h0);
    wr(2'd0, 32'hC);
    chk("R8 dma route", {30'd0, irq, dma_req}, 32'h1);
    // R5 R6 write zeros (reserved ones) keep flag
    wr(2'd3, 32'hFFFF_FFFC);
    rd(2'd3, v); chk("R5 R6 zero write keeps", v, 32'h2);
    // R10 clear drops output next cycle
    @(negedge clk); wr_en = 1'b1; addr = 2'd3; wr_data = 32'h2;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 dma drops", {31'd0, dma_req}, 32'h0);
    rd(2'd3, v); chk("R6 w1c clears", v, 32'h0);

    // R7 set wins over clear
    wr(2'd0, 32'h4);
    tgt = cnt_model + 32'd6;
    wr(2'd1, tgt);
    repeat (8) @(negedge clk);
    rd(2'd3, v); chk("R7 pre-set", v, 32'h2);
    tgt = cnt_model + 32'd8;
    wr(2'd1, tgt);
    while (cnt_model != tgt) @(negedge clk);
    wr_en = 1'b1; addr = 2'd3; wr_data = 32'h2;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd3, v); chk("R7 set beats clear", v, 32'h2);
    chk("R7 irq held", {31'd0, irq}, 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule